// File: doc/BRIEF.md
# PHY Mailbox Command Sequencer

This block carries one firmware command to an external PHY over a small mailbox of clause-45 registers. The host gives it a 16-bit command code, up to five 16-bit argument words, an argument count and a handshake-variant select, and then pulses `start_i`. The block drives a simple register-bus master through the whole exchange. It waits until the PHY firmware can accept a command, loads the argument words, writes the command code, and waits for completion. On success it reads the argument words back. It returns a 2-bit result with the updated words.

Two handshakes are supported. In the legacy handshake, the block first forces the mailbox open with a write to the status register. It then waits for the open code, and it ends a successful command with a clear-complete write. In the newer handshake, the block only waits until the status register no longer reports a running command or a busy system. Each polling phase is limited to a fixed number of reads. Between reads the block pauses for a programmable number of clock cycles, so a millisecond-scale pause on silicon can be a few cycles in simulation.

Top module: `phy_mbox_seq`

## Requirements
- R1: Every bus access uses device address 30 (`CTL_DEV`). The only register addresses are command 0x4005, status 0x4037 and argument words 0x4038 to 0x403C, where word i sits at 0x4038+i.
- R2: One access is outstanding at a time. `bus_req_o`, `bus_we_o`, `bus_addr_o` and `bus_wdata_o` hold steady from request until the cycle `bus_done_i` is seen. Read data is taken from `bus_rdata_i` in that cycle.
- R3: With `legacy_i`=0, the first phase reads status repeatedly until a value other than 0x0002 or 0xBBBB is returned.
- R4: With `legacy_i`=1, the block first writes 0xA5A5 to status. It then reads status repeatedly until it returns `OPEN_CODE` (default 0x0010).
- R5: Once ready, the block writes argument word i to address 0x4038+i for i = 0 up to n-1, then writes the command code to 0x4005. Here n is `argc_i` clamped to 5, and n = 0 writes no argument word.
- R6: After the command write, the block reads status until it returns 0x0004 (pass) or 0x0008 (error). The error code ends the command with result 2'b10, with no read-back and no clear write.
- R7: Each polling phase makes at most `MAX_POLL` (300) status reads. Successive reads in a phase are separated by at least `delay_i` idle bus cycles. Running out of reads ends with result 2'b01 in the ready phase and 2'b10 in the completion phase.
- R8: On pass, the block reads addresses 0x4038 up to 0x4038+n-1 into argument slots 0 to n-1 of `args_o`. Result is 2'b00. Slots not read back keep the words captured at start (slot i at bits 16i+15:16i).
- R9: With `legacy_i`=1 only, a passing command ends with a write of 0x0080 to status after the read-back.
- R10: `start_i` is taken only while idle. All inputs are captured at start. `busy_o` rises the cycle after start and stays high through a one-cycle `done_o` pulse, after which the block is idle.
- R11: After reset `busy_o`, `done_o` and `bus_req_o` are 0, `result_o` is 2'b00 and `args_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken when idle |
| legacy_i | input | 1 | 1 selects the legacy handshake |
| cmd_i | input | 16 | Firmware command code |
| argc_i | input | 3 | Argument count, clamped to 5 |
| args_i | input | 80 | Argument words, word i at bits 16i+15:16i |
| delay_i | input | 20 | Idle cycles between polls |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 00 pass, 01 not ready, 10 error or completion timeout |
| args_o | output | 80 | Argument slots after the command |
| bus_req_o | output | 1 | Register access request |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_dev_o | output | 5 | Clause-45 device address |
| bus_addr_o | output | 16 | Register address |
| bus_wdata_o | output | 16 | Write data |
| bus_rdata_i | input | 16 | Read data |
| bus_done_i | input | 1 | Access complete |

## Verification
Some properties are checked on every cycle by the assertions:
- the bus request stays stable until it completes;
- every address falls inside the mailbox map;
- the done pulse lasts one cycle, and busy never drops without it;
- the clear-complete write happens only in the legacy handshake;
- no poll counter passes its limit.

Other behaviour only the bench scenarios can show: the ordering of the whole access sequence, the choice of ready code per variant, the exact 300-read boundary in each phase, the spacing between polls, the clamping of the argument count, and the read-back data landing in the right slots.

// File: rtl/phy_mbox_pkg.sv
package phy_mbox_pkg;
  localparam logic [15:0] ADDR_CMD    = 16'h4005;
  localparam logic [15:0] ADDR_STAT   = 16'h4037;
  localparam logic [15:0] ADDR_DATA1  = 16'h4038;
  localparam logic [15:0] ST_RUNNING  = 16'h0002;
  localparam logic [15:0] ST_SYS_BUSY = 16'hBBBB;
  localparam logic [15:0] ST_PASS     = 16'h0004;
  localparam logic [15:0] ST_ERROR    = 16'h0008;
  localparam logic [15:0] ST_FORCE    = 16'hA5A5;
  localparam logic [15:0] ST_CLEAR    = 16'h0080;

  typedef enum logic [1:0] {
    RES_PASS      = 2'b00,
    RES_NOT_READY = 2'b01,
    RES_FAIL      = 2'b10
  } res_e;

  typedef enum logic [3:0] {
    S_IDLE, S_FORCE, S_RDY_RD, S_RDY_WAIT, S_ARG_WR, S_CMD_WR,
    S_CPL_RD, S_CPL_WAIT, S_BACK_RD, S_CLEAR, S_FIN
  } st_e;
endpackage

// File: rtl/mbox_poll_ctr.sv
module mbox_poll_ctr #(
  parameter int unsigned MAX_POLL = 300,
  parameter int unsigned DLY_W    = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             miss_i,
  input  logic             tick_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             last_o,
  output logic             dly_zero_o
);
  localparam int unsigned TW = $clog2(MAX_POLL + 1);

  logic [TW-1:0]    tries_q;
  logic [DLY_W-1:0] dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tries_q <= '0;
      dly_q   <= '0;
    end else if (clr_i) begin
      tries_q <= '0;
      dly_q   <= '0;
    end else if (miss_i) begin
      tries_q <= tries_q + 1'b1;
      dly_q   <= dly_i;
    end else if (tick_i && dly_q != '0) begin
      dly_q <= dly_q - 1'b1;
    end
  end

  assign last_o     = (tries_q == TW'(MAX_POLL - 1));
  assign dly_zero_o = (dly_q == '0);

  a_r7_tries_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tries_q < TW'(MAX_POLL));
  a_r7_miss_not_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_i |-> !last_o);
endmodule

// File: rtl/mbox_arg_bank.sv
module mbox_arg_bank #(
  parameter int unsigned NA = 5,
  parameter int unsigned DW = 16,
  parameter int unsigned IW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [NA*DW-1:0] args_i,
  input  logic            wr_i,
  input  logic [IW-1:0]   idx_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [NA*DW-1:0] args_o,
  output logic [DW-1:0]   word_o
);
  logic [DW-1:0] slot_q [NA];

  for (genvar g = 0; g < NA; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        slot_q[g] <= '0;
      else if (load_i)                    slot_q[g] <= args_i[g*DW +: DW];
      else if (wr_i && idx_i == IW'(g))   slot_q[g] <= wdata_i;
    end
    assign args_o[g*DW +: DW] = slot_q[g];
  end

  always_comb begin
    word_o = '0;
    for (int k = 0; k < NA; k++) if (idx_i == IW'(k)) word_o = slot_q[k];
  end
endmodule

// File: rtl/phy_mbox_seq.sv
module phy_mbox_seq
  import phy_mbox_pkg::*;
#(
  parameter int unsigned MAX_ARGS  = 5,
  parameter int unsigned MAX_POLL  = 300,
  parameter int unsigned DLY_W     = 20,
  parameter logic [4:0]  CTL_DEV   = 5'd30,
  parameter logic [15:0] OPEN_CODE = 16'h0010,
  localparam int unsigned DW = 16,
  localparam int unsigned CW = $clog2(MAX_ARGS + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   legacy_i,
  input  logic [DW-1:0]          cmd_i,
  input  logic [CW-1:0]          argc_i,
  input  logic [MAX_ARGS*DW-1:0] args_i,
  input  logic [DLY_W-1:0]       delay_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [1:0]             result_o,
  output logic [MAX_ARGS*DW-1:0] args_o,
  output logic                   bus_req_o,
  output logic                   bus_we_o,
  output logic [4:0]             bus_dev_o,
  output logic [15:0]            bus_addr_o,
  output logic [DW-1:0]          bus_wdata_o,
  input  logic [DW-1:0]          bus_rdata_i,
  input  logic                   bus_done_i
);
  localparam logic [CW-1:0] N_MAX = CW'(MAX_ARGS);

  st_e              st_q, st_d;
  logic             legacy_q;
  logic [DW-1:0]    cmd_q;
  logic [CW-1:0]    n_q, idx_q, idx_d;
  logic [DLY_W-1:0] dly_q;
  res_e             res_q, res_d;
  logic             load, clr, miss, tick, bank_wr, last, dly_zero, rdy_ok, last_idx;
  logic [DW-1:0]    word;

  mbox_poll_ctr #(.MAX_POLL(MAX_POLL), .DLY_W(DLY_W)) u_poll (
    .clk_i, .rst_ni, .clr_i(clr), .miss_i(miss), .tick_i(tick),
    .dly_i(dly_q), .last_o(last), .dly_zero_o(dly_zero));

  mbox_arg_bank #(.NA(MAX_ARGS), .DW(DW), .IW(CW)) u_bank (
    .clk_i, .rst_ni, .load_i(load), .args_i(args_i), .wr_i(bank_wr),
    .idx_i(idx_q), .wdata_i(bus_rdata_i), .args_o(args_o), .word_o(word));

  assign rdy_ok   = legacy_q ? (bus_rdata_i == OPEN_CODE)
                             : (bus_rdata_i != ST_RUNNING && bus_rdata_i != ST_SYS_BUSY);
  assign last_idx = (idx_q == n_q - 1'b1);

  always_comb begin
    st_d = st_q; idx_d = idx_q; res_d = res_q;
    load = 1'b0; clr = 1'b0; miss = 1'b0; tick = 1'b0; bank_wr = 1'b0;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        load = 1'b1; clr = 1'b1; res_d = RES_PASS;
        st_d = legacy_i ? S_FORCE : S_RDY_RD;
      end
      S_FORCE: if (bus_done_i) st_d = S_RDY_RD;
      S_RDY_RD: if (bus_done_i) begin
        if (rdy_ok) begin
          idx_d = '0;
          st_d  = (n_q != '0) ? S_ARG_WR : S_CMD_WR;
        end else if (last) begin
          res_d = RES_NOT_READY; st_d = S_FIN;
        end else begin
          miss = 1'b1; st_d = S_RDY_WAIT;
        end
      end
      S_RDY_WAIT: begin
        tick = 1'b1;
        if (dly_zero) st_d = S_RDY_RD;
      end
      S_ARG_WR: if (bus_done_i) begin
        if (last_idx) st_d = S_CMD_WR;
        else          idx_d = idx_q + 1'b1;
      end
      S_CMD_WR: if (bus_done_i) begin
        clr = 1'b1; st_d = S_CPL_RD;
      end
      S_CPL_RD: if (bus_done_i) begin
        if (bus_rdata_i == ST_PASS) begin
          idx_d = '0;
          if (n_q != '0)    st_d = S_BACK_RD;
          else if (legacy_q) st_d = S_CLEAR;
          else               st_d = S_FIN;
        end else if (bus_rdata_i == ST_ERROR || last) begin
          res_d = RES_FAIL; st_d = S_FIN;
        end else begin
          miss = 1'b1; st_d = S_CPL_WAIT;
        end
      end
      S_CPL_WAIT: begin
        tick = 1'b1;
        if (dly_zero) st_d = S_CPL_RD;
      end
      S_BACK_RD: if (bus_done_i) begin
        bank_wr = 1'b1;
        if (last_idx) st_d = legacy_q ? S_CLEAR : S_FIN;
        else          idx_d = idx_q + 1'b1;
      end
      S_CLEAR: if (bus_done_i) st_d = S_FIN;
      S_FIN:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; legacy_q <= 1'b0; cmd_q <= '0; n_q <= '0;
      idx_q <= '0; dly_q <= '0; res_q <= RES_PASS;
    end else begin
      st_q <= st_d; idx_q <= idx_d; res_q <= res_d;
      if (load) begin
        legacy_q <= legacy_i;
        cmd_q    <= cmd_i;
        n_q      <= (argc_i > N_MAX) ? N_MAX : argc_i;
        dly_q    <= delay_i;
      end
    end
  end

  always_comb begin
    bus_req_o = 1'b1; bus_we_o = 1'b0; bus_addr_o = ADDR_STAT; bus_wdata_o = '0;
    unique case (st_q)
      S_FORCE:   begin bus_we_o = 1'b1; bus_wdata_o = ST_FORCE; end
      S_RDY_RD, S_CPL_RD: ;
      S_ARG_WR:  begin bus_we_o = 1'b1; bus_addr_o = ADDR_DATA1 + 16'(idx_q); bus_wdata_o = word; end
      S_CMD_WR:  begin bus_we_o = 1'b1; bus_addr_o = ADDR_CMD; bus_wdata_o = cmd_q; end
      S_BACK_RD: bus_addr_o = ADDR_DATA1 + 16'(idx_q);
      S_CLEAR:   begin bus_we_o = 1'b1; bus_wdata_o = ST_CLEAR; end
      default:   bus_req_o = 1'b0;
    endcase
  end

  assign bus_dev_o = CTL_DEV;
  assign busy_o    = (st_q != S_IDLE);
  assign done_o    = (st_q == S_FIN);
  assign result_o  = res_q;

  a_r2_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_done_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)
                                  && $stable(bus_wdata_o));
  a_r1_addr_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> bus_addr_o == ADDR_CMD || bus_addr_o == ADDR_STAT ||
                  (bus_addr_o >= ADDR_DATA1 && bus_addr_o < ADDR_DATA1 + 16'(MAX_ARGS)));
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  a_r10_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o |=> busy_o);
  a_r9_clear_legacy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o && bus_addr_o == ADDR_STAT && bus_wdata_o == ST_CLEAR |-> legacy_q);
endmodule

// File: tb/sim_phy_mbox_seq.sv
`timescale 1ns/1ps
module sim_phy_mbox_seq;
  localparam logic [15:0] A_CMD = 16'h4005, A_STAT = 16'h4037, A_D1 = 16'h4038;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, legacy = 1'b0;
  logic [15:0] cmd_in = '0;
  logic [2:0]  argc_in = '0;
  logic [79:0] args_in = '0;
  logic [19:0] delay = '0;
  logic busy, done, bus_req, bus_we, bus_done = 1'b0;
  logic [1:0] result;
  logic [79:0] args_out;
  logic [4:0] bus_dev;
  logic [15:0] bus_addr, bus_wdata, bus_rdata = '0;

  always #10 clk = ~clk;

  phy_mbox_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .legacy_i(legacy), .cmd_i(cmd_in),
    .argc_i(argc_in), .args_i(args_in), .delay_i(delay), .busy_o(busy), .done_o(done),
    .result_o(result), .args_o(args_out), .bus_req_o(bus_req), .bus_we_o(bus_we),
    .bus_dev_o(bus_dev), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_rdata_i(bus_rdata), .bus_done_i(bus_done));

  int tests = 0, fails = 0;
  logic        log_we [1024];
  logic [15:0] log_addr [1024], log_data [1024];
  logic        exp_we [1024];
  logic [15:0] exp_addr [1024], exp_data [1024];
  int log_n, exp_n;
  int m_rmiss, m_cmiss, m_dly, m_rdy, m_cpl, lat, idle;
  bit m_ferr, m_leg, m_cmd, act, prev_stat, gap_bad, proto_bad, dev_bad;
  logic [15:0] rb_base, resp;

  function automatic logic [15:0] rbv(input int i);
    return rb_base ^ 16'(16'h1111 * (i + 1));
  endfunction

  // register-bus PHY model
  always @(posedge clk) begin
    bus_done <= 1'b0;
    if (!rst_n) begin
      act = 0; idle = 0;
    end else if (act) begin
      if (!bus_req) proto_bad = 1;
      if (lat == 0) begin bus_done <= 1'b1; bus_rdata <= resp; act = 0; end
      else lat--;
    end else if (bus_req && !bus_done) begin
      if (bus_dev != 5'd30) dev_bad = 1;
      if (bus_addr == A_STAT && !bus_we && prev_stat && idle < m_dly) gap_bad = 1;
      prev_stat = (bus_addr == A_STAT && !bus_we);
      idle = 0; act = 1; lat = int'($urandom % 4);
      if (log_n < 1024) begin
        log_we[log_n] = bus_we; log_addr[log_n] = bus_addr;
        log_data[log_n] = bus_we ? bus_wdata : 16'h0; log_n++;
      end
      resp = 16'h0;
      if (bus_we && bus_addr == A_CMD) m_cmd = 1;
      if (!bus_we && bus_addr == A_STAT) begin
        if (!m_cmd) begin
          if (m_rdy < m_rmiss) resp = m_leg ? 16'h0000 : ((m_rdy % 2) != 0 ? 16'hBBBB : 16'h0002);
          else                 resp = m_leg ? 16'h0010 : 16'h0001;
          m_rdy++;
        end else begin
          if (m_cpl < m_cmiss) resp = (m_cpl % 2) != 0 ? 16'h0001 : 16'h0002;
          else                 resp = m_ferr ? 16'h0008 : 16'h0004;
          m_cpl++;
        end
      end else if (!bus_we) resp = rbv(int'(bus_addr - A_D1));
    end else idle++;
  end

  task automatic chk(input bit ok, input string what, input logic [79:0] act_v, input logic [79:0] exp_v);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", what, act_v, exp_v);
    end
  endtask

  task automatic push(input logic we, input logic [15:0] a, input logic [15:0] d);
    exp_we[exp_n] = we; exp_addr[exp_n] = a; exp_data[exp_n] = d; exp_n++;
  endtask

  task automatic run(input bit leg, input logic [15:0] cmd, input int argc, input logic [79:0] args,
                     input int dly, input int rmiss, input int cmiss, input bit ferr);
    int n = (argc > 5) ? 5 : argc;
    int cyc = 0, bad = -1;
    logic [1:0] er = 2'b00;
    logic [79:0] ea = args;
    string tg;
    m_rmiss = rmiss; m_cmiss = cmiss; m_ferr = ferr; m_leg = leg; m_dly = dly;
    m_rdy = 0; m_cpl = 0; m_cmd = 0; log_n = 0; prev_stat = 0;
    gap_bad = 0; proto_bad = 0; dev_bad = 0; rb_base = 16'($urandom);
    exp_n = 0;
    if (leg) push(1, A_STAT, 16'hA5A5);
    for (int k = 0; k < ((rmiss + 1 > 300) ? 300 : rmiss + 1); k++) push(0, A_STAT, 0);
    if (rmiss >= 300) er = 2'b01;
    else begin
      for (int i = 0; i < n; i++) push(1, A_D1 + 16'(i), args[i*16 +: 16]);
      push(1, A_CMD, cmd);
      for (int k = 0; k < ((cmiss + 1 > 300) ? 300 : cmiss + 1); k++) push(0, A_STAT, 0);
      if (cmiss >= 300 || ferr) er = 2'b10;
      else begin
        for (int i = 0; i < n; i++) begin push(0, A_D1 + 16'(i), 0); ea[i*16 +: 16] = rbv(i); end
        if (leg) push(1, A_STAT, 16'h0080);
      end
    end
    @(negedge clk);
    start = 1; legacy = leg; cmd_in = cmd; argc_in = 3'(argc); args_in = args; delay = 20'(dly);
    @(negedge clk);
    start = 0; cmd_in = ~cmd; args_in = ~args; argc_in = 3'd2; legacy = ~leg;
    chk(busy == 1'b1, "R10 busy after start", {79'd0, busy}, 80'd1);
    while (!done && cyc < 60000) begin
      start = (cyc == 3);
      @(negedge clk); cyc++;
    end
    start = 0;
    chk(cyc < 60000, "R10 done reached", 80'(cyc), 80'd60000);
    tg = (er == 2'b01) ? "R7 ready timeout result" :
         (er == 2'b10) ? (ferr ? "R6 error result" : "R7 completion timeout result") : "R8 pass result";
    chk(result == er, tg, 80'(result), 80'(er));
    chk(args_out == ea, "R8 argument slots", args_out, ea);
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (bad < 0 && (log_we[i] != exp_we[i] || log_addr[i] != exp_addr[i] ||
          (exp_we[i] && log_data[i] != exp_data[i]))) bad = i;
    if (bad < 0 && log_n != exp_n) bad = (log_n < exp_n) ? log_n : exp_n;
    chk(bad < 0, leg ? "R1 R4 R5 R9 access sequence" : "R1 R3 R5 access sequence",
        (bad < 0) ? 80'(log_n) : {31'd0, log_we[bad], log_addr[bad], log_data[bad], 16'(bad)},
        (bad < 0) ? 80'(exp_n) : {31'd0, exp_we[bad], exp_addr[bad], exp_data[bad], 16'(bad)});
    chk(!gap_bad, "R7 poll spacing", {79'd0, gap_bad}, 80'd0);
    chk(!proto_bad && !dev_bad, "R2 R1 handshake and device", {78'd0, proto_bad, dev_bad}, 80'd0);
    @(negedge clk);
    chk(!busy && !done, "R10 idle after done", {78'd0, busy, done}, 80'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; tests++;
    $display("FAIL R10 watchdog act=hung exp=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1357));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !bus_req && result == 2'b00 && args_out == '0, "R11 reset state",
        {busy, done, bus_req, result, args_out[74:0]}, 80'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run(0, 16'h8009, 1, 80'h1, 0, 299, 0, 0);
    run(0, 16'h8009, 1, 80'h1, 0, 300, 0, 0);
    run(1, 16'h8008, 2, 80'h2222_1111, 1, 0, 300, 0);
    run(1, 16'h8001, 5, 80'h5555_4444_3333_2222_1111, 2, 2, 1, 1);
    run(1, 16'h8008, 0, 80'hABCD, 1, 1, 2, 0);
    run(0, 16'h8001, 7, 80'hEEEE_DDDD_CCCC_BBBB_AAAA, 3, 3, 3, 0);
    run(0, 16'h8009, 0, 80'h0, 0, 0, 0, 0);
    for (int t = 0; t < 16; t++) begin
      logic [15:0] c;
      case ($urandom % 3) 0: c = 16'h8001; 1: c = 16'h8008; default: c = 16'h8009; endcase
      run(bit'($urandom % 2), c, int'($urandom % 8), {16'($urandom), 32'($urandom), 32'($urandom)},
          int'($urandom % 4), int'($urandom % 5), int'($urandom % 5), ($urandom % 4) == 0);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule